// File: doc/BRIEF.md
# DMA and Interrupt Control Register Bank

This block is a small bank of byte-wide control registers for a parallel DMA interface card. A host bus reaches it through a byte address, write and read strobes, and 8-bit data paths. Three offsets are decoded. A read/write channel register holds a 3-bit code that picks both the DMA request line and the port width (byte or word) in one field. A read/write interrupt register holds a 4-bit interrupt level that is turned into a one-hot interrupt line select. A read-only status byte reports four sticky transfer flags and a pending interrupt request.

The pending request is armed by a rising edge of an internal event input. Once it is set, it ignores further events until software reads the status byte. That read returns the current status, then clears the request and the flags on the same clock edge, which re-arms interrupt generation. One channel code is illegal. When it is programmed, no DMA request line is driven and a flag reports the bad configuration. Interrupt levels that have no matching host line drive no line. Level 2 is redirected to line 9.

Top module: `dma_irq_regbank`

## Requirements
- R1: The channel register is at offset 8, the interrupt register at offset 9 and the status byte at offset 10 (0xA). A read of any other offset returns 0, and a write to any other offset changes no register.
- R2: After reset, both read/write registers read 0, the status byte reads 0 and `irq_req` is 0.
- R3: Both read/write registers keep all 8 written bits, including the bits that no decoder uses, and read them back unchanged.
- R4: Channel code bits [2:0] values 0 to 3 drive `dreq_sel` bit n with `word_mode`=0. Values 5 to 7 drive `dreq_sel` bit n with `word_mode`=1. `dreq_sel` is always one-hot or zero.
- R5: Channel code 4 (binary 100) is illegal. It drives `dreq_sel`=0 and `word_mode`=0, and it raises `illegal_cfg`, which is 0 for every other code.
- R6: Interrupt register bits [3:0] values 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15 drive `irq_line_sel` bit equal to the value. Value 2 drives bit 9. Values 0, 1, 8 and 13 drive no bit.
- R7: Status byte layout: bit 0 transfer done, bit 1 transfer flag, bit 2 overrun, bit 3 underrun, bits 6:4 read 0, bit 7 pending request (equal to `irq_req`). Each flag becomes set after any clock edge at which its input is 1, and it stays set.
- R8: A read of offset 10 returns the status as it stood before the read. At that clock edge it clears all four flags and the pending request. The clear wins over a set in the same cycle.
- R9: The pending request becomes set after the clock edge at which `evt_in` is sampled 1, provided it was sampled 0 at the edge before (or at reset). While the request is set, further events have no effect. An event input held high through a clear does not set it again.
- R10: A write to offset 10 has no effect on the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (4) | Byte offset within the card window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| evt_in | input | 1 | Internal interrupt event, rising edge arms the request |
| xfer_done_in | input | 1 | Sets the transfer-done flag |
| xfer_flag_in | input | 1 | Sets the transfer flag |
| overrun_in | input | 1 | Sets the overrun flag |
| underrun_in | input | 1 | Sets the underrun flag |
| dreq_sel | output | 8 | One-hot DMA request line select |
| word_mode | output | 1 | 1 for word-wide port, 0 for byte-wide |
| illegal_cfg | output | 1 | Illegal channel code programmed |
| irq_line_sel | output | 16 | One-hot interrupt line select |
| irq_req | output | 1 | Pending interrupt request |

## Verification
The hardest case to reach from the ports is a status read that lands on the same edge as a rising event, with the event then held high afterwards. This must leave the request clear and not re-armed until a fresh rising edge. Directed sequences build that case on purpose. They also apply a rise while a request is already pending, and a write to the status offset while flags are set. Random cycles from a fixed seed mix writes to mapped and unmapped offsets, reads, and event pulses that carry random flag patterns. All 8 channel codes and all 16 interrupt levels are swept exhaustively.

// File: rtl/dma_irq_regbank_pkg.sv
package dma_irq_regbank_pkg;

  localparam int DATA_W    = 8;
  localparam int DMA_LINES = 8;
  localparam int IRQ_LINES = 16;
  localparam int CODE_W    = $clog2(DMA_LINES);
  localparam int LVL_W     = $clog2(IRQ_LINES);
  localparam int FLAG_N    = 4;

  typedef struct packed {
    logic [DMA_LINES-1:0] dreq;
    logic                 word;
    logic                 illegal;
  } dma_dec_t;

  // Channel code: top bit selects word width, code 100 is reserved.
  function automatic dma_dec_t dma_level_map(input logic [CODE_W-1:0] code);
    dma_dec_t r;
    r.dreq    = '0;
    r.word    = code[CODE_W-1];
    r.illegal = 1'b0;
    if (code == CODE_W'(4)) begin
      r.illegal = 1'b1;
      r.word    = 1'b0;
    end else begin
      r.dreq[code] = 1'b1;
    end
    return r;
  endfunction

  // Interrupt level to host line; level 2 is redirected to line 9.
  function automatic logic [IRQ_LINES-1:0] irq_line_map(input logic [LVL_W-1:0] lvl);
    logic [IRQ_LINES-1:0] r;
    r = '0;
    case (lvl)
      LVL_W'(0), LVL_W'(1), LVL_W'(8), LVL_W'(13): r = '0;
      LVL_W'(2): r[9] = 1'b1;
      default:   r[lvl] = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/byte_reg.sv
module byte_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/dma_level_decode.sv
module dma_level_decode
  import dma_irq_regbank_pkg::*;
(
  input  logic [CODE_W-1:0]    code,
  output logic [DMA_LINES-1:0] dreq_sel,
  output logic                 word_mode,
  output logic                 illegal_cfg
);
  dma_dec_t dec;
  always_comb begin
    dec         = dma_level_map(code);
    dreq_sel    = dec.dreq;
    word_mode   = dec.word;
    illegal_cfg = dec.illegal;
  end
endmodule

// File: rtl/irq_line_decode.sv
module irq_line_decode
  import dma_irq_regbank_pkg::*;
(
  input  logic [LVL_W-1:0]     lvl,
  output logic [IRQ_LINES-1:0] line_sel
);
  always_comb line_sel = irq_line_map(lvl);
endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
  parameter int FLAGS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt_in,
  input  logic [FLAGS-1:0] flag_set,
  output logic [FLAGS-1:0] flags,
  output logic             pending,
  output logic             evt_rise
);
  logic evt_q;

  assign evt_rise = evt_in & ~evt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q   <= 1'b0;
      flags   <= '0;
      pending <= 1'b0;
    end else begin
      evt_q <= evt_in;
      if (clr) begin
        flags   <= '0;
        pending <= 1'b0;
      end else begin
        flags <= flags | flag_set;
        if (evt_rise) pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_irq_regbank.sv
module dma_irq_regbank
  import dma_irq_regbank_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int OFS_CHAN = 8,
  parameter int OFS_IRQ  = 9,
  parameter int OFS_STAT = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 evt_in,
  input  logic                 xfer_done_in,
  input  logic                 xfer_flag_in,
  input  logic                 overrun_in,
  input  logic                 underrun_in,
  output logic [DMA_LINES-1:0] dreq_sel,
  output logic                 word_mode,
  output logic                 illegal_cfg,
  output logic [IRQ_LINES-1:0] irq_line_sel,
  output logic                 irq_req
);
  localparam int PAD_W = DATA_W - FLAG_N - 1;

  logic              hit_chan_w, hit_irq_w, hit_stat_w;
  logic              status_rd_w, evt_rise_w;
  logic [DATA_W-1:0] chan_q, irql_q, status_w;
  logic [FLAG_N-1:0] flags_w;

  assign hit_chan_w  = (bus_addr == ADDR_W'(OFS_CHAN));
  assign hit_irq_w   = (bus_addr == ADDR_W'(OFS_IRQ));
  assign hit_stat_w  = (bus_addr == ADDR_W'(OFS_STAT));
  assign status_rd_w = bus_rd & hit_stat_w;

  byte_reg #(.W(DATA_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .we(bus_wr & hit_chan_w), .d(bus_wdata), .q(chan_q)
  );

  byte_reg #(.W(DATA_W)) u_irql (
    .clk(clk), .rst_n(rst_n), .we(bus_wr & hit_irq_w), .d(bus_wdata), .q(irql_q)
  );

  dma_level_decode u_dma_dec (
    .code(chan_q[CODE_W-1:0]), .dreq_sel(dreq_sel),
    .word_mode(word_mode), .illegal_cfg(illegal_cfg)
  );

  irq_line_decode u_irq_dec (
    .lvl(irql_q[LVL_W-1:0]), .line_sel(irq_line_sel)
  );

  irq_status_latch #(.FLAGS(FLAG_N)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr(status_rd_w), .evt_in(evt_in),
    .flag_set({underrun_in, overrun_in, xfer_flag_in, xfer_done_in}),
    .flags(flags_w), .pending(irq_req), .evt_rise(evt_rise_w)
  );

  assign status_w = {irq_req, {PAD_W{1'b0}}, flags_w};

  always_comb begin
    bus_rdata = '0;
    if (hit_chan_w)      bus_rdata = chan_q;
    else if (hit_irq_w)  bus_rdata = irql_q;
    else if (hit_stat_w) bus_rdata = status_w;
  end
endmodule

// File: rtl/dma_irq_regbank_chk.sv
module dma_irq_regbank_chk
  import dma_irq_regbank_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [DMA_LINES-1:0] dreq_sel,
  input logic                 word_mode,
  input logic                 illegal_cfg,
  input logic [IRQ_LINES-1:0] irq_line_sel,
  input logic                 irq_req,
  input logic                 evt_rise,
  input logic                 status_rd
);
  a_r4_dreq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dreq_sel));

  a_r4_word_upper: assert property (@(posedge clk) disable iff (!rst_n)
    word_mode |-> (dreq_sel[7:5] != 3'b000));

  a_r5_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cfg |-> (dreq_sel == '0) && !word_mode);

  a_r6_line_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_line_sel));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> !irq_req);

  a_r9_sets_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rise && !status_rd) |=> irq_req);

  a_r9_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !status_rd) |=> irq_req);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !evt_rise) |=> !irq_req);
endmodule

bind dma_irq_regbank dma_irq_regbank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .dreq_sel(dreq_sel), .word_mode(word_mode),
  .illegal_cfg(illegal_cfg), .irq_line_sel(irq_line_sel), .irq_req(irq_req),
  .evt_rise(evt_rise_w), .status_rd(status_rd_w)
);

// File: tb/dma_irq_regbank_tb_top.sv
`timescale 1ns/1ps
module dma_irq_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        evt_in = 1'b0;
  logic [3:0]  fl_in = '0;
  logic [7:0]  dreq_sel;
  logic        word_mode, illegal_cfg, irq_req;
  logic [15:0] irq_line_sel;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m_chan, m_irql;
  logic [3:0] m_flags;
  logic       m_pend, m_evt_prev;

  always #2 clk = ~clk;

  dma_irq_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .xfer_done_in(fl_in[0]), .xfer_flag_in(fl_in[1]), .overrun_in(fl_in[2]),
    .underrun_in(fl_in[3]), .dreq_sel(dreq_sel), .word_mode(word_mode),
    .illegal_cfg(illegal_cfg), .irq_line_sel(irq_line_sel), .irq_req(irq_req)
  );

  function automatic logic [7:0] exp_dreq(input logic [2:0] c);
    return (c == 3'd4) ? 8'h00 : (8'h01 << c);
  endfunction

  function automatic logic [15:0] exp_line(input logic [3:0] l);
    case (l)
      4'd2:                              return 16'h0200;
      4'd3, 4'd4, 4'd5, 4'd6, 4'd7,
      4'd9, 4'd10, 4'd11, 4'd12,
      4'd14, 4'd15:                      return 16'h0001 << l;
      default:                           return 16'h0000;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'd8:    return m_chan;
      4'd9:    return m_irql;
      4'd10:   return {m_pend, 3'b000, m_flags};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    check("R4 dreq_sel", 32'(dreq_sel), 32'(exp_dreq(m_chan[2:0])));
    check("R4 word_mode", 32'(word_mode), 32'(m_chan[2:0] > 3'd4));
    check("R5 illegal_cfg", 32'(illegal_cfg), 32'(m_chan[2:0] == 3'd4));
    check("R6 irq_line_sel", 32'(irq_line_sel), 32'(exp_line(m_irql[3:0])));
    check("R7 irq_req", 32'(irq_req), 32'(m_pend));
  endtask

  // One bus cycle; read data is checked before the edge, model updated at the edge.
  task automatic cycle(input logic wr, input logic rd, input logic [3:0] a,
                       input logic [7:0] d, input logic ev, input logic [3:0] fl,
                       input string tag);
    logic rise;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; evt_in = ev; fl_in = fl;
    #1;
    if (rd) check(tag, 32'(bus_rdata), 32'(exp_read(a)));
    @(posedge clk);
    rise = ev && !m_evt_prev;
    if (rd && a == 4'd10) begin
      m_flags = '0; m_pend = 1'b0;
    end else begin
      m_flags = m_flags | fl;
      if (rise) m_pend = 1'b1;
    end
    m_evt_prev = ev;
    if (wr && a == 4'd8) m_chan = d;
    if (wr && a == 4'd9) m_irql = d;
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
    check_outputs();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_chan = '0; m_irql = '0; m_flags = '0; m_pend = 1'b0; m_evt_prev = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R2: reset state
    check_outputs();
    cycle(0, 1, 4'd8, 0, 0, 0, "R2 chan reset");
    cycle(0, 1, 4'd9, 0, 0, 0, "R2 irq reset");
    cycle(0, 1, 4'd10, 0, 0, 0, "R2 status reset");

    // R4 R5: every channel code, with upper bits set (R3)
    for (int c = 0; c < 8; c++) begin
      cycle(1, 0, 4'd8, {5'b10101, 3'(c)}, 0, 0, "R4 wr");
      cycle(0, 1, 4'd8, 0, 0, 0, "R3 chan readback");
    end
    // R6: every interrupt level
    for (int l = 0; l < 16; l++) begin
      cycle(1, 0, 4'd9, {4'b1100, 4'(l)}, 0, 0, "R6 wr");
      cycle(0, 1, 4'd9, 0, 0, 0, "R3 irq readback");
    end

    // R1: unmapped writes change nothing, unmapped reads give 0
    cycle(1, 0, 4'd0, 8'hFF, 0, 0, "R1 wr");
    cycle(1, 0, 4'd15, 8'hFF, 0, 0, "R1 wr");
    cycle(0, 1, 4'd8, 0, 0, 0, "R1 chan unchanged");
    cycle(0, 1, 4'd9, 0, 0, 0, "R1 irq unchanged");
    cycle(0, 1, 4'd11, 0, 0, 0, "R1 unmapped read");

    // R9: rise sets, second rise while pending ignored
    cycle(0, 0, 4'd0, 0, 1, 4'b0101, "R9");
    cycle(0, 0, 4'd0, 0, 0, 0, "R9");
    cycle(0, 0, 4'd0, 0, 1, 0, "R9");
    // R10: write to status ignored
    cycle(1, 0, 4'd10, 8'h00, 1, 0, "R10 wr");
    cycle(0, 1, 4'd10, 0, 1, 0, "R10 status intact");
    // R8: read clears; held-high event does not re-arm
    cycle(0, 0, 4'd0, 0, 1, 0, "R9 held");
    cycle(0, 1, 4'd10, 0, 1, 0, "R8 cleared");
    // R8: read on the same edge as a rise, clear wins
    cycle(0, 0, 4'd0, 0, 0, 0, "R8");
    cycle(0, 1, 4'd10, 0, 1, 4'b1000, "R8 same-edge read");
    cycle(0, 0, 4'd0, 0, 1, 0, "R8 no re-arm");
    cycle(0, 1, 4'd10, 0, 0, 0, "R8 clear won");
    cycle(0, 0, 4'd0, 0, 1, 4'b0010, "R9 fresh rise");
    cycle(0, 1, 4'd10, 0, 0, 0, "R7 status layout");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [3:0] a;
      op = int'($urandom % 4);
      a  = 4'(7 + ($urandom % 5));
      case (op)
        0: cycle(1, 0, a, 8'($urandom), 0, 0, "R3 rnd wr");
        1: cycle(0, 1, a, 0, 0, 0, (a == 4'd10) ? "R7 rnd status" : "R1 rnd read");
        default: cycle(0, 0, 4'd0, 0, 1'($urandom), 4'($urandom & 32'hF), "R9 rnd evt");
      endcase
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule